// File: doc/BRIEF.md
# Miss Status Holding Register File

This block keeps the cache non-blocking. It records every line that has missed and is still waiting for its refill, so the cache can go on serving hits and can accept further misses. A miss to a line that is not yet pending claims a free entry. The entry keeps the line address and the destination tag of that first miss, and the block asks external memory for the line through a valid/ready request port.

A later miss to a line whose refill has not come back does not go to memory again. It is merged into the same entry, which can hold up to four such secondary misses besides the first one. When memory answers with an entry number, the entry plays back its misses on the replay port, one per cycle: first the original miss, then the merged ones in the order they came in. The entry is freed on its last replay.

A miss that finds no room is refused through a combinational stall in the same cycle. Room runs out when no entry is free, or when the matching entry already holds four merged misses. The requester keeps the miss and presents it again later. Refill data, writebacks and data storage belong to other blocks.

Top module: `mshr_file`

## Requirements
- R1: After reset, req_valid, rep_valid and miss_stall are all 0.
- R2: An accepted miss (miss_valid high and miss_stall low at a clock edge) whose line has no pending entry claims the lowest free entry. From the next cycle, that entry's refill request is offered, with req_line equal to the miss line and req_id equal to the entry number.
- R3: An accepted miss whose line matches a pending entry (claimed, with no response yet) is merged into that entry and adds no refill request. At most one pending entry exists per line.
- R4: An entry holds at most four merged misses. A further miss to that line raises miss_stall in the same cycle, and the refused miss is never replayed.
- R5: When all entries are in use and the miss line matches no pending entry, miss_stall is high and the refused miss is never replayed. A merge into a non-full entry is still accepted.
- R6: Refill requests leave in the order their entries were claimed. While req_valid is high and req_ready is low, req_line and req_id hold their values.
- R7: In the cycles after a response (rsp_valid with rsp_id), the entry replays one miss per cycle on rep_valid/rep_line/rep_dest: the first miss, then the merged ones in arrival order.
- R8: An entry is freed after its last replay. A later miss to the same line claims a new entry and issues a new refill request.
- R9: Every accepted miss is replayed exactly once, carrying its own destination tag and line.
- R10: miss_stall is high only while miss_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A miss is presented |
| miss_line | input | LINE_W | Line address of the miss |
| miss_dest | input | DEST_W | Destination tag of the miss |
| miss_stall | output | 1 | Miss refused this cycle |
| req_valid | output | 1 | Refill request offered |
| req_ready | input | 1 | Memory takes the request |
| req_line | output | LINE_W | Line to refill |
| req_id | output | IDW | Entry number of the request |
| rsp_valid | input | 1 | Refill returned |
| rsp_id | input | IDW | Entry whose refill returned |
| rep_valid | output | 1 | Replay issued this cycle |
| rep_line | output | LINE_W | Line of the replayed miss |
| rep_dest | output | DEST_W | Destination tag of the replayed miss |

## Verification
On every cycle, the assertions check four things: that a stall only accompanies a presented miss, that a request held back by memory keeps its line and entry number, that no two pending entries share a line, and that replays never outnumber accepted misses. Other behaviour only shows across whole sequences, and the directed scenarios cover it. These scenarios check the order of refill requests, the exact order and destination tags of replays, the refusal of a fifth merged miss and of a miss arriving when every entry is in use, the reuse of a line after its entry is freed, and that each accepted miss comes back exactly once.

// File: rtl/mshr_file.sv
module mshr_file #(
  parameter int NENT   = 32,
  parameter int SECN   = 4,
  parameter int LINE_W = 26,
  parameter int DEST_W = 8,
  localparam int IDW   = $clog2(NENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [LINE_W-1:0] miss_line,
  input  logic [DEST_W-1:0] miss_dest,
  output logic              miss_stall,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [LINE_W-1:0] req_line,
  output logic [IDW-1:0]    req_id,
  input  logic              rsp_valid,
  input  logic [IDW-1:0]    rsp_id,
  output logic              rep_valid,
  output logic [LINE_W-1:0] rep_line,
  output logic [DEST_W-1:0] rep_dest
);
  localparam int SLOTS = SECN + 1;
  localparam int CW    = $clog2(SLOTS + 1);

  logic [NENT-1:0]   vld, fill, hit;
  logic [LINE_W-1:0] line_q [NENT];
  logic [DEST_W-1:0] dest_q [NENT][SLOTS];
  logic [CW-1:0]     cnt_q  [NENT];
  logic [CW-1:0]     ptr_q  [NENT];
  logic [IDW-1:0]    fq     [NENT];
  logic [IDW-1:0]    wp, rp;
  logic [IDW:0]      fc;

  logic           any_hit, any_free, acc, alloc, merge, pop, last;
  logic [IDW-1:0] hit_id, free_id, rsel;

  always_comb begin
    any_hit = 1'b0;  hit_id  = '0;
    any_free = 1'b0; free_id = '0;
    rsel = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      hit[i] = vld[i] & ~fill[i] & (line_q[i] == miss_line);
      if (hit[i])  begin any_hit  = 1'b1; hit_id  = IDW'(i); end
      if (!vld[i]) begin any_free = 1'b1; free_id = IDW'(i); end
      if (fill[i]) rsel = IDW'(i);
    end
  end

  assign miss_stall = miss_valid & (any_hit ? (cnt_q[hit_id] == CW'(SLOTS)) : ~any_free);
  assign acc   = miss_valid & ~miss_stall;
  assign alloc = acc & ~any_hit;
  assign merge = acc & any_hit;

  assign req_valid = (fc != '0);
  assign req_id    = fq[rp];
  assign req_line  = line_q[fq[rp]];
  assign pop       = req_valid & req_ready;

  assign rep_valid = |fill;
  assign rep_line  = line_q[rsel];
  assign rep_dest  = dest_q[rsel][ptr_q[rsel]];
  assign last      = (ptr_q[rsel] == cnt_q[rsel] - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      fill <= '0;
      wp   <= '0;
      rp   <= '0;
      fc   <= '0;
      for (int i = 0; i < NENT; i++) begin
        cnt_q[i] <= '0;
        ptr_q[i] <= '0;
      end
    end else begin
      if (alloc) begin
        vld[free_id]       <= 1'b1;
        line_q[free_id]    <= miss_line;
        dest_q[free_id][0] <= miss_dest;
        cnt_q[free_id]     <= CW'(1);
        ptr_q[free_id]     <= '0;
        fq[wp]             <= free_id;
        wp                 <= wp + IDW'(1);
      end
      if (merge) begin
        dest_q[hit_id][cnt_q[hit_id]] <= miss_dest;
        cnt_q[hit_id]                 <= cnt_q[hit_id] + CW'(1);
      end
      if (pop) rp <= rp + IDW'(1);
      case ({alloc, pop})
        2'b10:   fc <= fc + (IDW+1)'(1);
        2'b01:   fc <= fc - (IDW+1)'(1);
        default: fc <= fc;
      endcase
      if (rsp_valid) fill[rsp_id] <= 1'b1;
      if (rep_valid) begin
        if (last) begin
          vld[rsel]  <= 1'b0;
          fill[rsel] <= 1'b0;
        end else begin
          ptr_q[rsel] <= ptr_q[rsel] + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
  parameter int NENT   = 32,
  parameter int SECN   = 4,
  parameter int LINE_W = 26,
  parameter int IDW    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_valid,
  input logic              miss_stall,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LINE_W-1:0] req_line,
  input logic [IDW-1:0]    req_id,
  input logic              rep_valid,
  input logic [NENT-1:0]   vld,
  input logic [NENT-1:0]   fill,
  input logic [LINE_W-1:0] line_q [NENT]
);
  int  outstanding;
  logic dup;

  always_ff @(posedge clk) begin
    if (!rst_n) outstanding <= 0;
    else outstanding <= outstanding + int'(miss_valid && !miss_stall) - int'(rep_valid);
  end

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < NENT; i++)
      for (int j = i + 1; j < NENT; j++)
        if (vld[i] && !fill[i] && vld[j] && !fill[j] && line_q[i] == line_q[j]) dup = 1'b1;
  end

  a_r10_stall_needs_miss: assert property (@(posedge clk) disable iff (!rst_n)
    miss_stall |-> miss_valid);

  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_line) && $stable(req_id));

  a_r3_one_pending_per_line: assert property (@(posedge clk) disable iff (!rst_n)
    !dup);

  a_r9_replay_backed: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> outstanding > 0);

  a_r9_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= NENT * (SECN + 1));
endmodule

bind mshr_file mshr_file_chk #(.NENT(NENT), .SECN(SECN), .LINE_W(LINE_W), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_stall(miss_stall),
  .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line), .req_id(req_id),
  .rep_valid(rep_valid), .vld(vld), .fill(fill), .line_q(line_q)
);

// File: tb/test_mshr_file.sv
`timescale 1ns/1ps
module test_mshr_file;
  localparam int NENT = 32, LINE_W = 26, DEST_W = 8, IDW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic miss_valid = 1'b0, req_ready = 1'b0, rsp_valid = 1'b0;
  logic [LINE_W-1:0] miss_line = '0;
  logic [DEST_W-1:0] miss_dest = '0;
  logic [IDW-1:0] rsp_id = '0;
  logic miss_stall, req_valid, rep_valid;
  logic [LINE_W-1:0] req_line, rep_line;
  logic [IDW-1:0] req_id;
  logic [DEST_W-1:0] rep_dest;

  int nchk = 0, nfail = 0, log_n = 0;
  int log_d [256];
  int log_l [256];

  always #2.5 clk = ~clk;

  mshr_file i_mshr_file (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_line(miss_line),
    .miss_dest(miss_dest), .miss_stall(miss_stall), .req_valid(req_valid),
    .req_ready(req_ready), .req_line(req_line), .req_id(req_id),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rep_valid(rep_valid),
    .rep_line(rep_line), .rep_dest(rep_dest)
  );

  always @(negedge clk) if (rst_n && rep_valid && log_n < 256) begin
    log_d[log_n] = int'(rep_dest);
    log_l[log_n] = int'(rep_line);
    log_n++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_miss(input int line, input int dest, output bit st);
    @(negedge clk);
    miss_valid = 1'b1; miss_line = LINE_W'(line); miss_dest = DEST_W'(dest);
    #1 st = miss_stall;
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic pop_req(output int id, output int line);
    @(negedge clk);
    req_ready = 1'b1;
    #1 id = int'(req_id); line = int'(req_line);
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  task automatic send_rsp(input int id);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_id = IDW'(id);
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk(req_valid == 1'b0, "R1", "req_valid", int'(req_valid), 0);
    chk(rep_valid == 1'b0, "R1", "rep_valid", int'(rep_valid), 0);
    chk(miss_stall == 1'b0, "R1", "miss_stall", int'(miss_stall), 0);
  endtask

  task automatic t_single;
    bit st; int id, ln;
    log_n = 0;
    do_miss('h100, 1, st);
    chk(st == 1'b0, "R2", "stall on fresh miss", int'(st), 0);
    #1;
    chk(req_valid == 1'b1, "R2", "req_valid", int'(req_valid), 1);
    pop_req(id, ln);
    chk(ln == 'h100, "R2", "req_line", ln, 'h100);
    chk(id == 0, "R2", "req_id lowest free", id, 0);
    #1 chk(req_valid == 1'b0, "R2", "single request", int'(req_valid), 0);
    send_rsp(id);
    repeat (4) @(negedge clk);
    chk(log_n == 1, "R9", "replay count", log_n, 1);
    chk(log_d[0] == 1 && log_l[0] == 'h100, "R7", "replay dest", log_d[0], 1);
    do_miss('h100, 2, st);
    #1 chk(req_valid == 1'b1, "R8", "reused line refetched", int'(req_valid), 1);
    pop_req(id, ln);
    send_rsp(id);
    repeat (4) @(negedge clk);
    chk(log_n == 2 && log_d[1] == 2, "R8", "replay after reuse", log_d[1], 2);
  endtask

  task automatic t_merge;
    bit st; int id, ln;
    log_n = 0;
    do_miss('h2a0, 10, st);
    pop_req(id, ln);
    chk(ln == 'h2a0, "R2", "req_line merge base", ln, 'h2a0);
    for (int k = 1; k <= 4; k++) begin
      do_miss('h2a0, 10 + k, st);
      chk(st == 1'b0, "R3", "merge accepted", int'(st), 0);
    end
    #1 chk(req_valid == 1'b0, "R3", "no extra refill", int'(req_valid), 0);
    do_miss('h2a0, 15, st);
    chk(st == 1'b1, "R4", "fifth merge stalls", int'(st), 1);
    send_rsp(id);
    repeat (8) @(negedge clk);
    chk(log_n == 5, "R4", "replays after refused merge", log_n, 5);
    for (int k = 0; k < 5; k++)
      chk(log_d[k] == 10 + k && log_l[k] == 'h2a0, "R7", "replay order", log_d[k], 10 + k);
  endtask

  task automatic t_full;
    bit st; int id, ln, hits;
    int ids [NENT];
    log_n = 0;
    for (int i = 0; i < NENT; i++) begin
      do_miss('h400 + i, 100 + i, st);
      if (st) chk(1'b0, "R2", "fill stall", 1, 0);
    end
    repeat (3) @(negedge clk);
    #1 chk(req_valid && req_line == 'h400, "R6", "held request", int'(req_line), 'h400);
    do_miss('h7ff, 250, st);
    chk(st == 1'b1, "R5", "stall when full", int'(st), 1);
    #1 chk(miss_stall == 1'b0, "R10", "no stall without miss", int'(miss_stall), 0);
    do_miss('h405, 200, st);
    chk(st == 1'b0, "R5", "merge while full", int'(st), 0);
    for (int i = 0; i < NENT; i++) begin
      pop_req(id, ln);
      ids[i] = id;
      if (ln != 'h400 + i) chk(1'b0, "R6", "request order", ln, 'h400 + i);
    end
    chk(1'b1, "R6", "request order", 0, 0);
    for (int i = NENT - 1; i >= 0; i--) send_rsp(ids[i]);
    repeat (40) @(negedge clk);
    chk(log_n == NENT + 1, "R9", "total replays", log_n, NENT + 1);
    for (int i = 0; i < NENT; i++) begin
      hits = 0;
      for (int k = 0; k < log_n; k++) if (log_d[k] == 100 + i && log_l[k] == 'h400 + i) hits++;
      if (hits != 1) chk(1'b0, "R9", "replayed once", hits, 1);
    end
    hits = 0;
    for (int k = 0; k < log_n; k++) if (log_d[k] == 200) hits++;
    chk(hits == 1, "R9", "merged replay once", hits, 1);
    hits = 0;
    for (int k = 0; k < log_n; k++) if (log_d[k] == 250) hits++;
    chk(hits == 0, "R5", "refused miss not replayed", hits, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_single;
    t_merge;
    t_full;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule